// File: doc/BRIEF.md
# NAND Interface Configuration Register Bank with Unlock Key

This block is a small register bank for a NAND flash controller. It holds two configuration words: the interface configuration word, with bus width, address length, page size and software write protection, and the interface timing word. Both words drive the rest of the controller through plain output pins. Software cannot change either word by accident. A write to a protected word takes effect only when a 16-bit unlock key was written to the lock register just before it.

One key write opens a window for exactly one protected write. When that write lands, the bank locks again by itself, so software that needs to update both words writes the key twice. Writes to non-protected addresses do not use up an open window. A command write carrying the reset code clears both protected words and locks the bank. Reads are combinational and always allowed, whatever the lock state.

The write port is a single-cycle strobe with per-byte enables. It has no back-pressure: every write is taken in the cycle in which `wr_en` is high.

Top module: `nand_cfg_regfile`

## Requirements
- R1: After reset the interface word and the timing word are zero, and the bank is locked (lock register bit 0 reads 1).
- R2: A write to the lock register (word address 2) with byte strobes 0 and 1 both set and data bits 15:0 equal to 0xA25E unlocks the bank from the next cycle. Lock register bit 0 then reads 0.
- R3: While the bank is locked, a write to the interface word (address 0) or the timing word (address 1) leaves the stored value unchanged, and the bank stays locked.
- R4: While the bank is unlocked, the first write to address 0 or 1 updates the register, and the bank locks again in the same edge. Any further protected write needs a new key.
- R5: Any lock register write that is not a valid key relocks the bank, or keeps it locked. This covers a wrong value and a key sent without both low byte strobes.
- R6: Writes to the command register that do not carry the reset code, and writes to unmapped addresses, neither change the lock state nor use up an open window.
- R7: A command write (address 3) with byte strobe 0 set and data bits 7:0 equal to 0xFF clears both protected words and locks the bank. The same write without strobe 0 has no effect.
- R8: Interface word bits map to pins as follows: bit 0 is `cfg_bus16`, bit 1 is `cfg_long_addr`, bit 2 is `cfg_large_blk` and bit 3 is `cfg_sw_wprot`. Bits 31:4 always read 0.
- R9: The timing word is 26 bits wide and bits 31:26 read 0. An accepted write updates only the bytes whose strobe is set, and the stored value drives `tim_cfg`.
- R10: Reads of addresses 0 to 2 return the stored contents combinationally in both lock states. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Word address for both read and write |
| wstrb | input | 4 | Byte enables for the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| cfg_bus16 | output | 1 | Selects a 16-bit NAND bus |
| cfg_long_addr | output | 1 | Selects 5-byte addressing |
| cfg_large_blk | output | 1 | Selects large-block pages |
| cfg_sw_wprot | output | 1 | Software write protection |
| tim_cfg | output | 26 | Timing word |
| locked | output | 1 | High while protected writes are refused |

## Verification
The lock sequence is driven with a correct key, a wrong value, a key sent on only one byte strobe, and a key followed by a second key. These cases separate a design that compares all 16 key bits from one that compares part of the key, and one that honours the strobes from one that ignores them. Protected writes are placed before any key, directly after a key, and after a command or unmapped write that falls between the key and the write. This shows whether the window is used up only by protected writes, and whether it closes after exactly one of them. Partial-strobe timing writes and all-ones writes show byte-lane masking and field width. Reset-code commands with and without strobe 0 show the clear path.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CFG_W  = 4;
  localparam int TIM_W  = 26;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [7:0]  CMD_RESET  = 8'hFF;

  localparam int A_IFCFG  = 0;
  localparam int A_TIMING = 1;
  localparam int A_LOCK   = 2;
  localparam int A_CMD    = 3;

  typedef struct packed {
    logic cfg;
    logic tim;
    logic lck;
    logic cmd;
  } reg_sel_t;
endpackage

// File: rtl/ncr_decode.sv
module ncr_decode
  import ncr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);
  always_comb begin
    sel     = '0;
    sel.cfg = (addr == AW'(A_IFCFG));
    sel.tim = (addr == AW'(A_TIMING));
    sel.lck = (addr == AW'(A_LOCK));
    sel.cmd = (addr == AW'(A_CMD));
  end
endmodule

// File: rtl/ncr_lock_ctrl.sv
module ncr_lock_ctrl
  import ncr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_t    sel,
  input  logic [1:0]  wstrb_lo,
  input  logic [15:0] wdata_lo,
  output logic        locked,
  output logic        grant,
  output logic        soft_rst
);
  logic locked_q;
  logic key_match;
  logic prot_wr;

  assign key_match = (&wstrb_lo) && (wdata_lo == UNLOCK_KEY);
  assign soft_rst  = wr_en && sel.cmd && wstrb_lo[0] && (wdata_lo[7:0] == CMD_RESET);
  assign prot_wr   = wr_en && (sel.cfg || sel.tim);
  assign grant     = prot_wr && !locked_q;
  assign locked    = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                locked_q <= 1'b1;
    else if (soft_rst)         locked_q <= 1'b1;
    else if (wr_en && sel.lck) locked_q <= !key_match;
    else if (grant)            locked_q <= 1'b1;
  end

  // R2: a valid key opens the window
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel.lck && (&wstrb_lo) && wdata_lo == 16'hA25E) |=> !locked);

  // R5: anything else written to the lock register leaves it locked
  p_bad_key_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel.lck && !((&wstrb_lo) && wdata_lo == 16'hA25E)) |=> locked);

  // R4: one protected write closes the window
  p_relock_after_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel.cfg || sel.tim) && !locked) |=> locked);

  // R6: other traffic does not change the lock state
  p_other_keeps_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (sel.cfg || sel.tim || sel.lck || sel.cmd))) |=> $stable(locked));
endmodule

// File: rtl/ncr_prot_reg.sv
module ncr_prot_reg #(
  parameter int W  = 8,
  parameter int NB = (W + 7) / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          grant,
  input  logic [NB-1:0] wstrb,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (grant) begin
      for (int i = 0; i < W; i++) begin
        if (wstrb[i/8]) q[i] <= wdata[i];
      end
    end
  end

  // R3: without a grant or clear the stored word cannot move
  p_hold_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !clr) |=> $stable(q));
endmodule

// File: rtl/ncr_rd_mux.sv
module ncr_rd_mux #(
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int TW = 26
) (
  input  logic          sel_cfg,
  input  logic          sel_tim,
  input  logic          sel_lck,
  input  logic [CW-1:0] cfg_q,
  input  logic [TW-1:0] tim_q,
  input  logic          locked,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel_cfg)      rdata = DW'(cfg_q);
    else if (sel_tim) rdata = DW'(tim_q);
    else if (sel_lck) rdata = DW'(locked);
  end
endmodule

// File: rtl/nand_cfg_regfile.sv
module nand_cfg_regfile
  import ncr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CFG_W,
  parameter int TW = TIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW/8-1:0] wstrb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          cfg_bus16,
  output logic          cfg_long_addr,
  output logic          cfg_large_blk,
  output logic          cfg_sw_wprot,
  output logic [TW-1:0] tim_cfg,
  output logic          locked
);
  localparam int CNB = (CW + 7) / 8;
  localparam int TNB = (TW + 7) / 8;

  reg_sel_t      sel;
  logic          grant;
  logic          soft_rst;
  logic [CW-1:0] cfg_q;
  logic [TW-1:0] tim_q;
  logic          unused_hi;

  assign unused_hi = ^wdata[DW-1:TW];

  ncr_decode #(.AW(AW)) u_dec (.addr(addr), .sel(sel));

  ncr_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
    .wstrb_lo(wstrb[1:0]), .wdata_lo(wdata[15:0]),
    .locked(locked), .grant(grant), .soft_rst(soft_rst)
  );

  ncr_prot_reg #(.W(CW), .NB(CNB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .grant(grant && sel.cfg),
    .wstrb(wstrb[CNB-1:0]), .wdata(wdata[CW-1:0]), .q(cfg_q)
  );

  ncr_prot_reg #(.W(TW), .NB(TNB)) u_tim (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .grant(grant && sel.tim),
    .wstrb(wstrb[TNB-1:0]), .wdata(wdata[TW-1:0]), .q(tim_q)
  );

  ncr_rd_mux #(.DW(DW), .CW(CW), .TW(TW)) u_rd (
    .sel_cfg(sel.cfg), .sel_tim(sel.tim), .sel_lck(sel.lck),
    .cfg_q(cfg_q), .tim_q(tim_q), .locked(locked), .rdata(rdata)
  );

  assign cfg_bus16     = cfg_q[0];
  assign cfg_long_addr = cfg_q[1];
  assign cfg_large_blk = cfg_q[2];
  assign cfg_sw_wprot  = cfg_q[3];
  assign tim_cfg       = tim_q;

  // R7: the reset command clears both words and relocks
  p_cmd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3) && wstrb[0] && wdata[7:0] == 8'hFF)
      |=> (tim_cfg == '0 && !cfg_bus16 && !cfg_long_addr && !cfg_large_blk
           && !cfg_sw_wprot && locked));

  // R3: a locked bank refuses protected writes
  p_locked_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && (addr == AW'(0) || addr == AW'(1))) |=> ($stable(tim_cfg) && locked));
endmodule

// File: tb/test_nand_cfg_regfile.sv
module test_nand_cfg_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cfg_bus16, cfg_long_addr, cfg_large_blk, cfg_sw_wprot, locked;
  logic [25:0] tim_cfg;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nand_cfg_regfile i_nand_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wstrb(wstrb),
    .wdata(wdata), .rdata(rdata), .cfg_bus16(cfg_bus16),
    .cfg_long_addr(cfg_long_addr), .cfg_large_blk(cfg_large_blk),
    .cfg_sw_wprot(cfg_sw_wprot), .tim_cfg(tim_cfg), .locked(locked)
  );

  // {waddr, wstrb, wdata, check addr, expected read, requirement}
  localparam int NV = 22;
  localparam logic [83:0] VEC [NV] = '{
    {4'h0, 4'hF, 32'hFFFFFFFF, 4'h0, 32'h00000000, 8'd3},  // R3 locked write ignored
    {4'h1, 4'hF, 32'hFFFFFFFF, 4'h2, 32'h00000001, 8'd3},  // R3 lock stays set
    {4'h2, 4'hF, 32'h00001234, 4'h2, 32'h00000001, 8'd5},  // R5 wrong value
    {4'h2, 4'h3, 32'h0000A25E, 4'h2, 32'h00000000, 8'd2},  // R2 key opens
    {4'h3, 4'h1, 32'h00000012, 4'h2, 32'h00000000, 8'd6},  // R6 other command
    {4'h7, 4'hF, 32'h0000A25E, 4'h2, 32'h00000000, 8'd6},  // R6 unmapped
    {4'h0, 4'hF, 32'hFFFFFFF6, 4'h0, 32'h00000006, 8'd8},  // R8 upper bits zero
    {4'h0, 4'hF, 32'h00000000, 4'h0, 32'h00000006, 8'd4},  // R4 second write refused
    {4'h1, 4'hF, 32'h01234567, 4'h1, 32'h00000000, 8'd4},  // R4 still locked
    {4'h2, 4'hF, 32'h0000A25E, 4'h2, 32'h00000000, 8'd2},  // R2 full strobes
    {4'h1, 4'h5, 32'hFFFFFFFF, 4'h1, 32'h00FF00FF, 8'd9},  // R9 byte lanes
    {4'h7, 4'h0, 32'h00000000, 4'h1, 32'h00FF00FF, 8'd10}, // R10 read while locked
    {4'h2, 4'h1, 32'h0000A25E, 4'h2, 32'h00000001, 8'd5},  // R5 one strobe only
    {4'h2, 4'h3, 32'h0000A25E, 4'h2, 32'h00000000, 8'd2},  // R2
    {4'h2, 4'h3, 32'h0000A25F, 4'h2, 32'h00000001, 8'd5},  // R5 relock while open
    {4'h2, 4'h3, 32'h0000A25E, 4'h2, 32'h00000000, 8'd2},  // R2
    {4'h1, 4'hF, 32'hFFFFFFFF, 4'h1, 32'h03FFFFFF, 8'd9},  // R9 width 26
    {4'h2, 4'h3, 32'h0000A25E, 4'h2, 32'h00000000, 8'd2},  // R2
    {4'h3, 4'hE, 32'h000000FF, 4'h2, 32'h00000000, 8'd7},  // R7 no strobe 0
    {4'h3, 4'h1, 32'h000000FF, 4'h0, 32'h00000000, 8'd7},  // R7 clears interface word
    {4'h7, 4'h0, 32'h00000000, 4'h1, 32'h00000000, 8'd7},  // R7 clears timing word
    {4'h7, 4'h0, 32'h00000000, 4'h2, 32'h00000001, 8'd7}   // R7 relocked
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; wstrb = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wstrb = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic reset_check(input string when);
    rd(4'h0, {"R1 interface word ", when}, 32'h0);
    rd(4'h1, {"R1 timing word ", when}, 32'h0);
    rd(4'h2, {"R1 lock bit ", when}, 32'h1);
    chk({"R1 pins ", when}, {26'(tim_cfg), cfg_bus16, cfg_long_addr, cfg_large_blk,
        cfg_sw_wprot, locked, 1'b0}, 32'h2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("after power-up");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][83:80], VEC[i][79:76], VEC[i][75:44]);
      rd(VEC[i][43:40], $sformatf("R%0d vector %0d", VEC[i][7:0], i), VEC[i][39:8]);
    end

    // R8 pin mapping
    wr(4'h2, 4'h3, 32'h0000A25E);
    wr(4'h0, 4'h1, 32'h00000009);
    #1;
    chk("R8 pins 0x9", {28'h0, cfg_sw_wprot, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'h9);
    wr(4'h2, 4'h3, 32'h0000A25E);
    wr(4'h0, 4'h1, 32'h00000006);
    #1;
    chk("R8 pins 0x6", {28'h0, cfg_sw_wprot, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'h6);

    // R9 timing pins, R4 relock visible on the pin
    wr(4'h2, 4'h3, 32'h0000A25E);
    wr(4'h1, 4'hF, 32'h02ABCDEF);
    #1;
    chk("R9 tim_cfg pins", 32'(tim_cfg), 32'h02ABCDEF);
    chk("R4 locked pin after use", 32'(locked), 32'h1);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("after mid-run reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule